// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block is the software-facing register file of a four-channel DMA engine. A processor reaches it over an 8-bit I/O bus with a 4-bit port offset. Each channel has a 16-bit start address and a 16-bit transfer count. Each of these is kept as a base copy and a working copy, and each is reached through a single byte-wide port. One low/high byte toggle, shared by all channels, decides which half of a 16-bit register a given access touches. The remaining offsets carry the command byte, the per-channel mode, the mask and request bits, the status byte, and three write-only strobes. The strobes rewind the byte toggle, reset the whole controller, or unmask every channel.

The stored fields are exported to the channel arbiter and the address generator. Terminal-count pulses come in from the transfer engine and are latched as sticky status flags. Software collects these flags by reading the status byte, and that read clears them. Read data is combinational from the current state. All side effects of an access (byte-toggle flip, flag clearing, register loads) take effect on the clock edge that ends the access cycle.

Top module: `dma_regfile`

## Requirements
- R1: A write to offset 2n (n = channel 0..3) stores the data byte into both the base and the working address of channel n. The byte goes to bits 7:0 when the byte toggle is low and to bits 15:8 when it is high.
- R2: A write to offset 2n+1 stores the data byte into both the base and the working count of channel n, with the same low/high rule as R1.
- R3: There is one byte toggle for all channels, and it is low after reset. Every read or write at offsets 0..7 flips it. A read at offset 2n or 2n+1 returns byte 7:0 (toggle low) or byte 15:8 (toggle high) of the working address or working count. Any write to offset 0xC forces the toggle low.
- R4: Any write to offset 0xD is a master clear, applied at the end of that cycle: the command becomes 0, all masks are set, all request bits and terminal-count flags are cleared (even against a same-cycle terminal-count pulse), all modes become 0, and the byte toggle goes low. Base and working addresses and counts keep their values.
- R5: Any write to offset 0xE clears all four mask bits. A write to offset 0xF loads mask bits 3:0 from data bits 3:0, where bit n belongs to channel n.
- R6: A write to offset 0xA uses data bits 1:0 to pick a channel. It sets that channel's mask when data bit 2 is 1 and clears it when bit 2 is 0. Other channels are untouched.
- R7: A write to offset 0x9 uses data bits 1:0 to pick a channel. It sets that channel's request bit when data bit 2 is 1 and clears it when bit 2 is 0.
- R8: A write to offset 0xB uses data bits 1:0 to pick a channel and stores data bits 7:2 as that channel's 6-bit mode, with mode bits 5:0 taken from data bits 7:2:
  - mode bits 1:0 are the transfer type (00 verify, 01 write, 10 read);
  - mode bit 2 enables auto-initialization;
  - mode bit 3 selects increment (1) or decrement (0);
  - mode bits 5:4 are the service type (00 demand, 01 single, 10 block, 11 cascade).
- R9: A write to offset 0x8 stores the full data byte as the command byte.
- R10: A read of offset 0x8 returns the status byte: bits 3:0 are the terminal-count flags of channels 0..3 and bits 7:4 are their request bits. A pulse on tc_evt bit n sets flag n at the next edge. Reads of offsets 0x9..0xF return 0.
- R11: A read of offset 0x8 clears all terminal-count flags at the end of the read cycle. A terminal-count pulse in that same cycle still leaves its flag set.
- R12: After reset the masks are all set, and the command, modes, request bits, flags, addresses and counts are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for this cycle; takes precedence over rd_en |
| rd_en | input | 1 | Read strobe for this cycle |
| addr | input | 4 | Port offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the current state |
| tc_evt | input | NCH | Terminal-count pulses from the transfer engine |
| cmd_o | output | 8 | Command byte |
| mask_o | output | NCH | Channel mask bits |
| req_o | output | NCH | Software request bits |
| mode_o | output | NCH*6 | Per-channel mode, 6 bits per channel |
| base_addr_o | output | NCH*16 | Base addresses |
| cur_addr_o | output | NCH*16 | Working addresses |
| base_cnt_o | output | NCH*16 | Base counts |
| cur_cnt_o | output | NCH*16 | Working counts |

## Verification
A write takes effect on the exported fields one edge after the cycle in which wr_en is high. Read data belongs to the cycle in which rd_en is high and depends on the byte toggle as it stands before that cycle's edge. The toggle flip and the flag clearing that a read causes show up only on the next access. The bench drives each access one nanosecond after a rising edge and samples at the following falling edge. Its reference model updates only on rising edges, so every comparison sees the post-edge state against the same-cycle read data.

// File: rtl/dma_rf_pkg.sv
`timescale 1ns/1ps
package dma_rf_pkg;
   localparam int BYTE_W = 8;
   localparam int REG_W  = 16;
   localparam int REG_NB = REG_W / BYTE_W;
   localparam int OFFS_W = 4;
   localparam int MODE_W = 6;
   localparam int MAX_CH = 4;

   typedef enum logic [OFFS_W-1:0] {
      OFF_CMD_STAT = 4'h8,
      OFF_REQ      = 4'h9,
      OFF_SMASK    = 4'hA,
      OFF_MODE     = 4'hB,
      OFF_BPCLR    = 4'hC,
      OFF_MCLR     = 4'hD,
      OFF_UNMASK   = 4'hE,
      OFF_MASKALL  = 4'hF
   } port_e;

   typedef struct packed {
      logic [1:0] svc;
      logic       incr;
      logic       autoinit;
      logic [1:0] xfer;
   } mode_t;
endpackage

// File: rtl/dma_rf_decode.sv
`timescale 1ns/1ps
module dma_rf_decode
   import dma_rf_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [OFFS_W-1:0] addr,
   output logic              acc_reg,
   output logic              reg_ld,
   output logic              is_cnt,
   output logic [NCH-1:0]    ch_sel,
   output logic              wr_cmd,
   output logic              wr_req,
   output logic              wr_smask,
   output logic              wr_mode,
   output logic              wr_bpclr,
   output logic              wr_mclr,
   output logic              wr_unmask,
   output logic              wr_maskall,
   output logic              rd_status
);
   logic is_reg;
   logic do_rd;

   assign is_reg  = ~addr[OFFS_W-1];
   assign do_rd   = rd_en & ~wr_en;
   assign acc_reg = is_reg & (wr_en | rd_en);
   assign reg_ld  = is_reg & wr_en;
   assign is_cnt  = addr[0];

   for (genvar i = 0; i < NCH; i++) begin : g_sel
      assign ch_sel[i] = (addr[2:1] == 2'(i));
   end

   assign wr_cmd     = wr_en && (addr == OFF_CMD_STAT);
   assign wr_req     = wr_en && (addr == OFF_REQ);
   assign wr_smask   = wr_en && (addr == OFF_SMASK);
   assign wr_mode    = wr_en && (addr == OFF_MODE);
   assign wr_bpclr   = wr_en && (addr == OFF_BPCLR);
   assign wr_mclr    = wr_en && (addr == OFF_MCLR);
   assign wr_unmask  = wr_en && (addr == OFF_UNMASK);
   assign wr_maskall = wr_en && (addr == OFF_MASKALL);
   assign rd_status  = do_rd && (addr == OFF_CMD_STAT);
endmodule

// File: rtl/dma_rf_pair.sv
`timescale 1ns/1ps
module dma_rf_pair
   import dma_rf_pkg::*;
#(
   parameter int W = REG_W,
   localparam int NB = W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NB-1:0]     ld,
   input  logic [BYTE_W-1:0] wdata,
   output logic [W-1:0]      base,
   output logic [W-1:0]      cur
);
   if (W % BYTE_W != 0) begin : g_bad_w
      $error("dma_rf_pair: W must be a whole number of bytes");
   end

   for (genvar b = 0; b < NB; b++) begin : g_byte
      logic [BYTE_W-1:0] base_b;
      logic [BYTE_W-1:0] cur_b;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_b <= '0;
            cur_b  <= '0;
         end else if (ld[b]) begin
            base_b <= wdata;
            cur_b  <= wdata;
         end
      end

      assign base[b*BYTE_W +: BYTE_W] = base_b;
      assign cur[b*BYTE_W +: BYTE_W]  = cur_b;
   end
endmodule

// File: rtl/dma_rf_ctrl.sv
`timescale 1ns/1ps
module dma_rf_ctrl
   import dma_rf_pkg::*;
#(
   parameter int NCH              = 4,
   parameter bit STAT_CLR_ON_READ = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         acc_reg,
   input  logic                         wr_cmd,
   input  logic                         wr_req,
   input  logic                         wr_smask,
   input  logic                         wr_mode,
   input  logic                         wr_bpclr,
   input  logic                         wr_mclr,
   input  logic                         wr_unmask,
   input  logic                         wr_maskall,
   input  logic                         rd_status,
   input  logic [BYTE_W-1:0]            wdata,
   input  logic [NCH-1:0]               tc_evt,
   output logic [BYTE_W-1:0]            cmd_q,
   output logic [NCH-1:0]               mask_q,
   output logic [NCH-1:0]               req_q,
   output logic [NCH-1:0]               tc_q,
   output logic                         bp_q,
   output logic [NCH-1:0][MODE_W-1:0]   mode_q
);
   logic [NCH-1:0] sel_dec;
   logic [NCH-1:0] tc_keep;
   mode_t          new_mode;

   assign new_mode = mode_t'(wdata[BYTE_W-1:2]);

   for (genvar i = 0; i < NCH; i++) begin : g_dec
      assign sel_dec[i] = (wdata[1:0] == 2'(i));
   end

   if (STAT_CLR_ON_READ) begin : g_rdclr
      assign tc_keep = rd_status ? '0 : '1;
   end else begin : g_sticky
      assign tc_keep = '1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_q <= 1'b0;
      end else if (wr_mclr || wr_bpclr) begin
         bp_q <= 1'b0;
      end else if (acc_reg) begin
         bp_q <= ~bp_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (wr_mclr) begin
         cmd_q <= '0;
      end else if (wr_cmd) begin
         cmd_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (wr_mclr) begin
         mask_q <= '1;
      end else if (wr_unmask) begin
         mask_q <= '0;
      end else if (wr_maskall) begin
         mask_q <= wdata[NCH-1:0];
      end else if (wr_smask) begin
         mask_q <= wdata[2] ? (mask_q | sel_dec) : (mask_q & ~sel_dec);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
      end else if (wr_mclr) begin
         req_q <= '0;
      end else if (wr_req) begin
         req_q <= wdata[2] ? (req_q | sel_dec) : (req_q & ~sel_dec);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q <= '0;
      end else if (wr_mclr) begin
         tc_q <= '0;
      end else begin
         tc_q <= (tc_q & tc_keep) | tc_evt;
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q[i] <= '0;
         end else if (wr_mclr) begin
            mode_q[i] <= '0;
         end else if (wr_mode && sel_dec[i]) begin
            mode_q[i] <= new_mode;
         end
      end
   end
endmodule

// File: rtl/dma_regfile.sv
`timescale 1ns/1ps
module dma_regfile
   import dma_rf_pkg::*;
#(
   parameter int NCH              = 4,
   parameter bit STAT_CLR_ON_READ = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [3:0]          addr,
   input  logic [7:0]          wdata,
   output logic [7:0]          rdata,
   input  logic [NCH-1:0]      tc_evt,
   output logic [7:0]          cmd_o,
   output logic [NCH-1:0]      mask_o,
   output logic [NCH-1:0]      req_o,
   output logic [NCH*6-1:0]    mode_o,
   output logic [NCH*16-1:0]   base_addr_o,
   output logic [NCH*16-1:0]   cur_addr_o,
   output logic [NCH*16-1:0]   base_cnt_o,
   output logic [NCH*16-1:0]   cur_cnt_o
);
   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("dma_regfile: NCH must lie in 1..4");
   end
   if (REG_NB != 2) begin : g_bad_reg
      $error("dma_regfile: one byte toggle needs two-byte registers");
   end

   logic                       acc_reg, reg_ld, is_cnt;
   logic [NCH-1:0]             ch_sel;
   logic                       wr_cmd, wr_req, wr_smask, wr_mode, wr_bpclr;
   logic                       wr_mclr, wr_unmask, wr_maskall, rd_status;
   logic                       bp_q;
   logic [NCH-1:0]             tc_q;
   logic [NCH-1:0]             mask_q, req_q;
   logic [BYTE_W-1:0]          cmd_q;
   logic [NCH-1:0][MODE_W-1:0] mode_q;
   logic [REG_W-1:0]           base_a [NCH];
   logic [REG_W-1:0]           cur_a  [NCH];
   logic [REG_W-1:0]           base_c [NCH];
   logic [REG_W-1:0]           cur_c  [NCH];
   logic [BYTE_W-1:0]          stat;
   logic [REG_W-1:0]           word;

   dma_rf_decode #(.NCH(NCH)) u_dec (
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .addr       (addr),
      .acc_reg    (acc_reg),
      .reg_ld     (reg_ld),
      .is_cnt     (is_cnt),
      .ch_sel     (ch_sel),
      .wr_cmd     (wr_cmd),
      .wr_req     (wr_req),
      .wr_smask   (wr_smask),
      .wr_mode    (wr_mode),
      .wr_bpclr   (wr_bpclr),
      .wr_mclr    (wr_mclr),
      .wr_unmask  (wr_unmask),
      .wr_maskall (wr_maskall),
      .rd_status  (rd_status)
   );

   dma_rf_ctrl #(.NCH(NCH), .STAT_CLR_ON_READ(STAT_CLR_ON_READ)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_reg    (acc_reg),
      .wr_cmd     (wr_cmd),
      .wr_req     (wr_req),
      .wr_smask   (wr_smask),
      .wr_mode    (wr_mode),
      .wr_bpclr   (wr_bpclr),
      .wr_mclr    (wr_mclr),
      .wr_unmask  (wr_unmask),
      .wr_maskall (wr_maskall),
      .rd_status  (rd_status),
      .wdata      (wdata),
      .tc_evt     (tc_evt),
      .cmd_q      (cmd_q),
      .mask_q     (mask_q),
      .req_q      (req_q),
      .tc_q       (tc_q),
      .bp_q       (bp_q),
      .mode_q     (mode_q)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic [REG_NB-1:0] ld_byte;
      logic [REG_NB-1:0] ld_a;
      logic [REG_NB-1:0] ld_c;

      assign ld_byte = bp_q ? 2'b10 : 2'b01;
      assign ld_a    = (reg_ld && ch_sel[i] && !is_cnt) ? ld_byte : '0;
      assign ld_c    = (reg_ld && ch_sel[i] &&  is_cnt) ? ld_byte : '0;

      dma_rf_pair #(.W(REG_W)) u_addr (
         .clk   (clk),
         .rst_n (rst_n),
         .ld    (ld_a),
         .wdata (wdata),
         .base  (base_a[i]),
         .cur   (cur_a[i])
      );

      dma_rf_pair #(.W(REG_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .ld    (ld_c),
         .wdata (wdata),
         .base  (base_c[i]),
         .cur   (cur_c[i])
      );

      assign base_addr_o[i*REG_W +: REG_W] = base_a[i];
      assign cur_addr_o[i*REG_W +: REG_W]  = cur_a[i];
      assign base_cnt_o[i*REG_W +: REG_W]  = base_c[i];
      assign cur_cnt_o[i*REG_W +: REG_W]   = cur_c[i];
      assign mode_o[i*MODE_W +: MODE_W]    = mode_q[i];
   end

   assign cmd_o  = cmd_q;
   assign mask_o = mask_q;
   assign req_o  = req_q;

   always_comb begin
      stat            = '0;
      stat[NCH-1:0]   = tc_q;
      stat[4 +: NCH]  = req_q;
   end

   always_comb begin
      word = '0;
      for (int i = 0; i < NCH; i++) begin
         if (addr[2:1] == 2'(i)) begin
            word = is_cnt ? cur_c[i] : cur_a[i];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (!addr[3]) begin
         rdata = bp_q ? word[15:8] : word[7:0];
      end else if (addr == OFF_CMD_STAT) begin
         rdata = stat;
      end
   end
endmodule

// File: rtl/dma_regfile_chk.sv
`timescale 1ns/1ps
module dma_regfile_chk #(
   parameter int NCH              = 4,
   parameter bit STAT_CLR_ON_READ = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [3:0]        addr,
   input logic [7:0]        wdata,
   input logic [NCH-1:0]    tc_evt,
   input logic [7:0]        cmd_o,
   input logic [NCH-1:0]    mask_o,
   input logic [NCH-1:0]    req_o,
   input logic [NCH*6-1:0]  mode_o,
   input logic [NCH*16-1:0] cur_addr_o,
   input logic              bp_q,
   input logic [NCH-1:0]    tc_q
);
   assert_addr_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 4'h0 && !bp_q) |=> (cur_addr_o[7:0] == $past(wdata)));

   assert_bp_rewind_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 4'hC) |=> !bp_q);

   assert_mclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 4'hD) |=> (mask_o == '1 && req_o == '0 && tc_q == '0 && cmd_o == 8'h00));

   assert_unmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 4'hE) |=> (mask_o == '0));

   assert_smask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 4'hA && wdata[2] && wdata[1:0] == 2'd0) |=> mask_o[0]);

   assert_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 4'h9 && !wdata[2] && wdata[1:0] == 2'd0) |=> !req_o[0]);

   assert_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 4'hB && wdata[1:0] == 2'd0) |=> (mode_o[5:0] == $past(wdata[7:2])));

   assert_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 4'h8) |=> (cmd_o == $past(wdata)));

   assert_tc_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_evt != '0 && !(wr_en && addr == 4'hD)) |=> ((tc_q & $past(tc_evt)) == $past(tc_evt)));

   if (STAT_CLR_ON_READ) begin : g_rdclr
      assert_stat_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && !wr_en && addr == 4'h8 && tc_evt == '0) |=> (tc_q == '0));
   end
endmodule

bind dma_regfile dma_regfile_chk #(.NCH(NCH), .STAT_CLR_ON_READ(STAT_CLR_ON_READ)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .addr       (addr),
   .wdata      (wdata),
   .tc_evt     (tc_evt),
   .cmd_o      (cmd_o),
   .mask_o     (mask_o),
   .req_o      (req_o),
   .mode_o     (mode_o),
   .cur_addr_o (cur_addr_o),
   .bp_q       (bp_q),
   .tc_q       (tc_q)
);

// File: tb/tb_dma_regfile.sv
`timescale 1ns/1ps
module tb_dma_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = 4'h0;
   logic [7:0]  wdata = 8'h00;
   logic [3:0]  tc_evt = 4'h0;
   logic [7:0]  rdata;
   logic [7:0]  cmd_o;
   logic [3:0]  mask_o, req_o;
   logic [23:0] mode_o;
   logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit started = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dma_regfile dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tc_evt(tc_evt), .cmd_o(cmd_o),
      .mask_o(mask_o), .req_o(req_o), .mode_o(mode_o),
      .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o),
      .base_cnt_o(base_cnt_o), .cur_cnt_o(cur_cnt_o)
   );

   // behavioural reference state
   logic [15:0] m_ba [4];
   logic [15:0] m_ca [4];
   logic [15:0] m_bc [4];
   logic [15:0] m_cc [4];
   logic [5:0]  m_mode [4];
   logic [7:0]  m_cmd;
   logic [3:0]  m_mask, m_req, m_tc;
   bit          m_bp;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
         end
         m_cmd = 0; m_mask = 4'hF; m_req = 0; m_tc = 0; m_bp = 0;
         started = 1'b1;
      end else begin
         int ch;
         ch = addr / 2;
         if (wr_en) begin
            if (addr < 8) begin
               if (addr % 2 == 1) begin
                  if (m_bp) begin m_bc[ch][15:8] = wdata; m_cc[ch][15:8] = wdata; end
                  else      begin m_bc[ch][7:0]  = wdata; m_cc[ch][7:0]  = wdata; end
               end else begin
                  if (m_bp) begin m_ba[ch][15:8] = wdata; m_ca[ch][15:8] = wdata; end
                  else      begin m_ba[ch][7:0]  = wdata; m_ca[ch][7:0]  = wdata; end
               end
               m_bp = !m_bp;
               m_tc = m_tc | tc_evt;
            end else if (addr == 4'hD) begin
               m_cmd = 0; m_mask = 4'hF; m_req = 0; m_tc = 0; m_bp = 0;
               for (int i = 0; i < 4; i++) m_mode[i] = 0;
            end else begin
               case (addr)
                  4'h8: m_cmd = wdata;
                  4'h9: m_req[wdata[1:0]] = wdata[2];
                  4'hA: m_mask[wdata[1:0]] = wdata[2];
                  4'hB: m_mode[wdata[1:0]] = wdata[7:2];
                  4'hC: m_bp = 0;
                  4'hE: m_mask = 0;
                  4'hF: m_mask = wdata[3:0];
                  default: ;
               endcase
               m_tc = m_tc | tc_evt;
            end
         end else if (rd_en) begin
            if (addr < 8) m_bp = !m_bp;
            if (addr == 4'h8) m_tc = tc_evt;
            else m_tc = m_tc | tc_evt;
         end else begin
            m_tc = m_tc | tc_evt;
         end
      end
   end

   function automatic logic [7:0] exp_rdata();
      logic [15:0] w;
      if (addr < 8) begin
         w = (addr % 2 == 1) ? m_cc[addr/2] : m_ca[addr/2];
         return m_bp ? w[15:8] : w[7:0];
      end
      if (addr == 4'h8) return {m_req, m_tc};
      return 8'h00;
   endfunction

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (started && !done) begin
         for (int i = 0; i < 4; i++) begin
            chk("R1 base_addr", base_addr_o[i*16 +: 16], m_ba[i]);
            chk("R1 cur_addr",  cur_addr_o[i*16 +: 16],  m_ca[i]);
            chk("R2 base_cnt",  base_cnt_o[i*16 +: 16],  m_bc[i]);
            chk("R2 cur_cnt",   cur_cnt_o[i*16 +: 16],   m_cc[i]);
            chk("R8 mode",      mode_o[i*6 +: 6],        m_mode[i]);
         end
         chk("R9 cmd",  cmd_o,  m_cmd);
         chk("R5 mask", mask_o, m_mask);
         chk("R7 req",  req_o,  m_req);
         if (rd_en && !wr_en) begin
            if (addr < 8) chk("R3 rdata", rdata, exp_rdata());
            else          chk("R10 rdata", rdata, exp_rdata());
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         failures++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
         finish_run();
      end
   end

   task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
      @(posedge clk); #1;
      rd_en = 1'b1; addr = a;
      #1;
      d = rdata;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic tc_pulse(input logic [3:0] m);
      @(posedge clk); #1;
      tc_evt = m;
      @(posedge clk); #1;
      tc_evt = 4'h0;
   endtask

   initial begin
      logic [7:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R12: reset state
      @(posedge clk); #1;
      chk("R12 mask after reset", mask_o, 4'hF);
      chk("R12 cmd after reset", cmd_o, 8'h00);
      chk("R12 req after reset", req_o, 4'h0);
      chk("R12 addr after reset", cur_addr_o, 64'h0);
      bus_rd(4'h8, d);
      chk("R12 status after reset", d, 8'h00);

      // R1: channel 1 address, low then high
      bus_wr(4'hC, 8'h00);
      bus_wr(4'h2, 8'h34);
      bus_wr(4'h2, 8'h12);
      chk("R1 ch1 base address", base_addr_o[31:16], 16'h1234);
      chk("R1 ch1 working address", cur_addr_o[31:16], 16'h1234);

      // R3: byte toggle on reads and rewind
      bus_rd(4'h2, d);
      chk("R3 low byte read", d, 8'h34);
      bus_rd(4'h2, d);
      chk("R3 high byte read", d, 8'h12);
      bus_rd(4'h2, d);
      bus_wr(4'hC, 8'hFF);
      bus_rd(4'h2, d);
      chk("R3 low byte after rewind", d, 8'h34);
      bus_wr(4'hC, 8'h00);

      // R2: channel 3 count
      bus_wr(4'h7, 8'hCD);
      bus_wr(4'h7, 8'hAB);
      chk("R2 ch3 base count", base_cnt_o[63:48], 16'hABCD);
      chk("R2 ch3 working count", cur_cnt_o[63:48], 16'hABCD);

      // R9 command, R8 mode
      bus_wr(4'h8, 8'h5A);
      chk("R9 command", cmd_o, 8'h5A);
      bus_wr(4'hB, 8'hB7);
      chk("R8 ch3 mode", mode_o[23:18], 6'h2D);
      chk("R8 ch0 mode untouched", mode_o[5:0], 6'h00);

      // R5 clear-all and load-all masks
      bus_wr(4'hE, 8'h00);
      chk("R5 unmask all", mask_o, 4'h0);
      bus_wr(4'hF, 8'h0A);
      chk("R5 load masks", mask_o, 4'hA);

      // R6 single mask
      bus_wr(4'hA, 8'h06);
      chk("R6 set ch2 mask", mask_o, 4'hE);
      bus_wr(4'hA, 8'h03);
      chk("R6 clear ch3 mask", mask_o, 4'h6);

      // R10 / R11 terminal count
      tc_pulse(4'h4);
      bus_rd(4'h8, d);
      chk("R10 status shows ch2 tc", d, 8'h04);
      bus_rd(4'h8, d);
      chk("R11 status cleared by read", d, 8'h00);
      bus_rd(4'h9, d);
      chk("R10 write-only offset reads zero", d, 8'h00);

      // R7 request
      bus_wr(4'h9, 8'h05);
      chk("R7 request ch1", req_o, 4'h2);
      bus_rd(4'h8, d);
      chk("R7 request in status", d, 8'h20);

      // R4 master clear
      bus_wr(4'hE, 8'h00);
      bus_wr(4'h2, 8'h77);
      bus_wr(4'hD, 8'h00);
      chk("R4 masks set", mask_o, 4'hF);
      chk("R4 requests cleared", req_o, 4'h0);
      chk("R4 command cleared", cmd_o, 8'h00);
      chk("R4 mode cleared", mode_o[23:18], 6'h00);
      chk("R4 address kept", cur_addr_o[31:16], 16'h1277);
      bus_rd(4'h2, d);
      chk("R4 toggle low after clear", d, 8'h77);

      // mixed traffic against the reference model
      for (int n = 0; n < 3000; n++) begin
         int op;
         @(posedge clk); #1;
         op = $urandom_range(0, 99);
         wr_en = 1'b0; rd_en = 1'b0;
         addr = 4'($urandom_range(0, 15));
         wdata = 8'($urandom);
         tc_evt = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'h0;
         if (addr == 4'hD && $urandom_range(0, 7) != 0) addr = 4'hB;
         if (op < 45) wr_en = 1'b1;
         else if (op < 85) rd_en = 1'b1;
      end
      @(posedge clk); #1;
      wr_en = 1'b0; rd_en = 1'b0; tc_evt = 4'h0;
      @(posedge clk); #1;
      finish_run();
   end
endmodule